// File: doc/BRIEF.md
# Shaped Tile Register File

This block stores eight two-dimensional tile registers. Each tile has up to 16 rows, and each row is 64 bytes wide. A 64-byte shape descriptor is written into the block at run time. It sets one row count and one row width for each tile, plus a shared resume-row index.

Software-visible commands move data between the tiles and memory:
- A load brings a tile in from memory, one row per handshake. Row r is read at `base + r*stride`.
- A store sends rows out the same way.
- A zero command clears the shaped area of one tile.

A compute engine reads and writes whole rows through a separate port. An external abort stops a load or store part-way. The resume-row field then holds the first row not yet moved, so the same command issued again carries on from that row.

The controller is a four-state machine:
- **IDLE** accepts commands. Descriptor writes, zero commands and rejected commands all finish inside IDLE in one cycle.
- **LOAD** waits for memory-read handshakes. It goes to TAIL after the last row, or back to IDLE on abort.
- **TAIL** clears the rows above the row count in one cycle, then returns to IDLE.
- **STORE** waits for memory-write handshakes. It returns to IDLE after the last row or on abort.

There are two more transitions out of IDLE. A load whose resume row is already at or past the row count goes straight to TAIL. A store in the same position finishes in IDLE.

Top module: `tile_regfile`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done_o` and `err_o` are 0, `cfg_out` is all zeros and every tile row reads as zero.
- R2: The descriptor byte layout is: byte 0 holds the palette, byte 1 the resume row, byte 16+t the row count of tile t, and byte 48+t the row width in bytes of tile t. All other bytes are ignored. A descriptor with palette 1 is stored. `cfg_out` then returns the stored fields in the same byte positions and zeros elsewhere. `done_o` is high, and `err_o` low, in the cycle after the accepting edge.
- R3: A descriptor is rejected if its palette is above 1, or (with palette 1) any row count is above 16, any width is above 64, or the resume row is above 15. On rejection, `err_o` and `done_o` go high together, and the configuration and tiles are unchanged.
- R4: A descriptor with palette 0 zeroes every tile and every shape, and makes `cfg_out` all zeros.
- R5: A load reads row r from `base + r*stride`, one row per `mrd_req`/`mrd_ack` handshake. A stride of 0 reads every row from `base`. Bytes at or above the tile's width are stored as zero. The address is held while the request waits.
- R6: When a load finishes, every row at or above the row count is all zeros, and the last row is followed by a single `done_o` pulse.
- R7: An abort during a load or store ends it at the next edge and discards any pending row. The resume-row field (`cfg_out` byte 1) then holds the next row to move. The next load or store starts at that row. A finished load or store sets the field back to 0. Every return to IDLE pulses `done_o`.
- R8: A store presents rows from the resume row up to row count minus 1, in ascending order. Each row is presented as a full row at `base + r*stride`, one per `mwr_req`/`mwr_ack` handshake.
- R9: A zero command clears, in one cycle, the bytes below the width in the rows below the row count of the selected tile. All other tiles are untouched.
- R10: A load, store or zero command is rejected if the palette is 0 or the tile's row count is 0. On rejection, `err_o` and `done_o` pulse, no memory request is made and no state changes.
- R11: `cmd_ready` is high only in IDLE, and a command offered while it is low is ignored. A compute write lands only in IDLE when no command is accepted in the same cycle. `mrd_req` and `mwr_req` are never high together.
- R12: The compute read port returns the selected row combinationally. A compute write replaces the whole row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | 0 descriptor write, 1 load, 2 store, 3 zero |
| cmd_tile | input | 3 | Selected tile |
| cmd_base | input | AW | Memory base address |
| cmd_stride | input | AW | Address step between rows |
| cmd_desc | input | 512 | Shape descriptor |
| cmd_ready | output | 1 | Idle, command can be taken |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Rejection pulse, high with done_o |
| cfg_out | output | 512 | Current descriptor readback |
| abort_i | input | 1 | Stops a running load or store |
| mrd_req | output | 1 | Memory read request |
| mrd_addr | output | AW | Memory read address |
| mrd_ack | input | 1 | Read data valid |
| mrd_data | input | RB*8 | Read row data |
| mwr_req | output | 1 | Memory write request |
| mwr_addr | output | AW | Memory write address |
| mwr_data | output | RB*8 | Write row data |
| mwr_ack | input | 1 | Write accepted |
| crd_tile | input | 3 | Compute read tile |
| crd_row | input | 4 | Compute read row |
| crd_data | output | RB*8 | Compute read data |
| cwr_en | input | 1 | Compute write enable |
| cwr_tile | input | 3 | Compute write tile |
| cwr_row | input | 4 | Compute write row |
| cwr_data | input | RB*8 | Compute write data |

## Verification
Descriptor writes, zero commands and rejections show their `done_o`/`err_o` pulse, and their effect on `cfg_out` and tile rows, in the first cycle after the accepting edge. The bench samples these at the falling edge one half-cycle later.

A load needs one handshake per row plus one TAIL cycle before `done_o`. A store needs one handshake per row. For both, the bench polls `done_o` at falling edges and then checks rows through the combinational read port.

Store rows are queued as expected items when the command is issued, and are compared as each write handshake is seen. The abort is raised only in a cycle with no pending acknowledge. The expected resume row is therefore exactly the number of handshakes counted so far.

// File: rtl/tile_pkg.sv
package tile_pkg;
    typedef enum logic [1:0] {
        OP_CFG   = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_ZERO  = 2'd3
    } tile_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_TAIL,
        ST_STORE
    } tile_st_e;

    localparam int DESC_BYTES = 64;
    localparam int POS_PAL    = 0;
    localparam int POS_START  = 1;
    localparam int POS_ROWS   = 16;
    localparam int POS_WIDTH  = 48;
endpackage

// File: rtl/tile_cfg_check.sv
module tile_cfg_check
    import tile_pkg::*;
#(
    parameter int NT = 8,
    parameter int NR = 16,
    parameter int RB = 64
) (
    input  logic [DESC_BYTES*8-1:0] desc,
    output logic                    ok,
    output logic                    is_zero_pal,
    output logic [7:0]              start,
    output logic [NT-1:0][7:0]      rows,
    output logic [NT-1:0][7:0]      widths
);
    logic [7:0] pal;
    logic       shape_ok;
    logic       unused_desc;

    assign unused_desc = ^desc;
    assign pal         = desc[POS_PAL*8 +: 8];
    assign start       = desc[POS_START*8 +: 8];
    assign is_zero_pal = (pal == 8'd0);

    always_comb begin
        shape_ok = (start < 8'(NR));
        for (int t = 0; t < NT; t++) begin
            rows[t]   = desc[(POS_ROWS + t)*8 +: 8];
            widths[t] = desc[(POS_WIDTH + t)*8 +: 8];
            if (rows[t] > 8'(NR) || widths[t] > 8'(RB)) shape_ok = 1'b0;
        end
        ok = is_zero_pal || (pal == 8'd1 && shape_ok);
    end
endmodule

// File: rtl/tile_byte_mask.sv
module tile_byte_mask #(
    parameter int RB = 64
) (
    input  logic [7:0]      width,
    output logic [RB*8-1:0] mask
);
    for (genvar i = 0; i < RB; i++) begin : g_byte
        assign mask[i*8 +: 8] = (8'(i) < width) ? 8'hFF : 8'h00;
    end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] stride,
    input  logic [7:0]    row,
    output logic [AW-1:0] addr
);
    assign addr = base + stride * AW'(row);
endmodule

// File: rtl/tile_regfile.sv
module tile_regfile
    import tile_pkg::*;
#(
    parameter int NT = 8,
    parameter int NR = 16,
    parameter int RB = 64,
    parameter int AW = 32,
    localparam int RW  = RB * 8,
    localparam int TIW = $clog2(NT),
    localparam int RIX = $clog2(NR),
    localparam int NE  = NT * NR,
    localparam int DW  = DESC_BYTES * 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [TIW-1:0] cmd_tile,
    input  logic [AW-1:0]  cmd_base,
    input  logic [AW-1:0]  cmd_stride,
    input  logic [DW-1:0]  cmd_desc,
    output logic           cmd_ready,
    output logic           done_o,
    output logic           err_o,
    output logic [DW-1:0]  cfg_out,
    input  logic           abort_i,
    output logic           mrd_req,
    output logic [AW-1:0]  mrd_addr,
    input  logic           mrd_ack,
    input  logic [RW-1:0]  mrd_data,
    output logic           mwr_req,
    output logic [AW-1:0]  mwr_addr,
    output logic [RW-1:0]  mwr_data,
    input  logic           mwr_ack,
    input  logic [TIW-1:0] crd_tile,
    input  logic [RIX-1:0] crd_row,
    output logic [RW-1:0]  crd_data,
    input  logic           cwr_en,
    input  logic [TIW-1:0] cwr_tile,
    input  logic [RIX-1:0] cwr_row,
    input  logic [RW-1:0]  cwr_data
);
    tile_st_e state_q, state_d;

    logic [RW-1:0]        mem [NE];
    logic                 pal_q;
    logic [7:0]           start_q;
    logic [NT-1:0][7:0]   rows_q, wid_q;
    logic [TIW-1:0]       tile_q;
    logic [AW-1:0]        base_q, stride_q;
    logic [7:0]           row_q;
    logic                 done_q, err_q;

    logic                 dsc_ok, dsc_zero;
    logic [7:0]           dsc_start;
    logic [NT-1:0][7:0]   dsc_rows, dsc_wid;
    logic [RW-1:0]        ld_mask, zr_mask;
    logic [AW-1:0]        xfer_addr;
    logic                 acc, cmd_bad, last_row;
    logic [7:0]           cur_rows;

    tile_cfg_check #(.NT(NT), .NR(NR), .RB(RB)) u_check (
        .desc(cmd_desc), .ok(dsc_ok), .is_zero_pal(dsc_zero),
        .start(dsc_start), .rows(dsc_rows), .widths(dsc_wid)
    );
    tile_byte_mask #(.RB(RB)) u_ld_mask (.width(wid_q[tile_q]),   .mask(ld_mask));
    tile_byte_mask #(.RB(RB)) u_zr_mask (.width(wid_q[cmd_tile]), .mask(zr_mask));
    tile_addr_gen  #(.AW(AW)) u_addr (
        .base(base_q), .stride(stride_q), .row(row_q), .addr(xfer_addr)
    );

    assign acc      = cmd_valid && (state_q == ST_IDLE);
    assign cmd_bad  = !pal_q || (rows_q[cmd_tile] == 8'd0);
    assign cur_rows = rows_q[tile_q];
    assign last_row = (row_q + 8'd1) >= cur_rows;
    assign crd_data = mem[{crd_tile, crd_row}];
    assign done_o   = done_q;
    assign err_o    = err_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc && !cmd_bad) begin
                    if (cmd_op == OP_LOAD)
                        state_d = (start_q >= rows_q[cmd_tile]) ? ST_TAIL : ST_LOAD;
                    else if (cmd_op == OP_STORE && start_q < rows_q[cmd_tile])
                        state_d = ST_STORE;
                end
            end
            ST_LOAD:  if (abort_i) state_d = ST_IDLE;
                      else if (mrd_ack && last_row) state_d = ST_TAIL;
            ST_TAIL:  state_d = ST_IDLE;
            ST_STORE: if (abort_i || (mwr_ack && last_row)) state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        mrd_req   = (state_q == ST_LOAD);
        mwr_req   = (state_q == ST_STORE);
        mrd_addr  = xfer_addr;
        mwr_addr  = xfer_addr;
        mwr_data  = mem[{tile_q, row_q[RIX-1:0]}];
        cfg_out   = '0;
        if (pal_q) begin
            cfg_out[POS_PAL*8 +: 8]   = 8'd1;
            cfg_out[POS_START*8 +: 8] = start_q;
            for (int t = 0; t < NT; t++) begin
                cfg_out[(POS_ROWS + t)*8 +: 8]  = rows_q[t];
                cfg_out[(POS_WIDTH + t)*8 +: 8] = wid_q[t];
            end
        end
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pal_q <= 1'b0; start_q <= '0; rows_q <= '0; wid_q <= '0;
            tile_q <= '0; base_q <= '0; stride_q <= '0; row_q <= '0;
            done_q <= 1'b0; err_q <= 1'b0;
            for (int i = 0; i < NE; i++) mem[i] <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (acc) begin
                        tile_q   <= cmd_tile;
                        base_q   <= cmd_base;
                        stride_q <= cmd_stride;
                        row_q    <= start_q;
                        if (cmd_op == OP_CFG) begin
                            done_q <= 1'b1;
                            if (!dsc_ok) err_q <= 1'b1;
                            else if (dsc_zero) begin
                                pal_q <= 1'b0; start_q <= '0; rows_q <= '0; wid_q <= '0;
                                for (int i = 0; i < NE; i++) mem[i] <= '0;
                            end else begin
                                pal_q <= 1'b1; start_q <= dsc_start;
                                rows_q <= dsc_rows; wid_q <= dsc_wid;
                            end
                        end else if (cmd_bad) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else if (cmd_op == OP_ZERO) begin
                            done_q <= 1'b1;
                            for (int r = 0; r < NR; r++)
                                if (8'(r) < rows_q[cmd_tile])
                                    mem[{cmd_tile, RIX'(r)}] <= mem[{cmd_tile, RIX'(r)}] & ~zr_mask;
                        end else if (cmd_op == OP_STORE && start_q >= rows_q[cmd_tile]) begin
                            done_q  <= 1'b1;
                            start_q <= '0;
                        end
                    end else if (cwr_en) begin
                        mem[{cwr_tile, cwr_row}] <= cwr_data;
                    end
                end
                ST_LOAD: begin
                    if (abort_i) begin
                        done_q  <= 1'b1;
                        start_q <= row_q;
                    end else if (mrd_ack) begin
                        mem[{tile_q, row_q[RIX-1:0]}] <= mrd_data & ld_mask;
                        row_q <= row_q + 8'd1;
                    end
                end
                ST_TAIL: begin
                    for (int r = 0; r < NR; r++)
                        if (8'(r) >= cur_rows) mem[{tile_q, RIX'(r)}] <= '0;
                    start_q <= '0;
                    done_q  <= 1'b1;
                end
                ST_STORE: begin
                    if (abort_i) begin
                        done_q  <= 1'b1;
                        start_q <= row_q;
                    end else if (mwr_ack) begin
                        row_q <= row_q + 8'd1;
                        if (last_row) begin
                            done_q  <= 1'b1;
                            start_q <= '0;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tile_regfile_chk.sv
module tile_regfile_chk #(
    parameter int AW = 32,
    parameter int DW = 512
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_ready,
    input logic          done_o,
    input logic          err_o,
    input logic [DW-1:0] cfg_out,
    input logic          abort_i,
    input logic          mrd_req,
    input logic [AW-1:0] mrd_addr,
    input logic          mrd_ack,
    input logic          mwr_req,
    input logic [AW-1:0] mwr_addr,
    input logic          mwr_ack
);
    // R11
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mrd_req && mwr_req));

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req || mwr_req) |-> !cmd_ready);

    // R3
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req && !mrd_ack && !abort_i) |=> (mrd_req && $stable(mrd_addr)));

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mwr_req && !mwr_ack && !abort_i) |=> (mwr_req && $stable(mwr_addr)));

    // R4
    unconfigured_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_out[7:0] == 8'd0) |-> (cfg_out == '0));

    // R7
    return_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> done_o);
endmodule

bind tile_regfile tile_regfile_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .done_o(done_o),
    .err_o(err_o), .cfg_out(cfg_out), .abort_i(abort_i),
    .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_ack(mrd_ack),
    .mwr_req(mwr_req), .mwr_addr(mwr_addr), .mwr_ack(mwr_ack)
);

// File: tb/sim_tile_regfile.sv
module sim_tile_regfile;
    localparam int AW = 32;
    localparam int RW = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic           cmd_valid = 1'b0;
    logic [1:0]     cmd_op = '0;
    logic [2:0]     cmd_tile = '0;
    logic [AW-1:0]  cmd_base = '0, cmd_stride = '0;
    logic [511:0]   cmd_desc = '0;
    logic           cmd_ready, done_o, err_o;
    logic [511:0]   cfg_out;
    logic           abort_i = 1'b0;
    logic           mrd_req, mrd_ack = 1'b0;
    logic [AW-1:0]  mrd_addr;
    logic [RW-1:0]  mrd_data = '0;
    logic           mwr_req, mwr_ack = 1'b0;
    logic [AW-1:0]  mwr_addr;
    logic [RW-1:0]  mwr_data;
    logic [2:0]     crd_tile = '0, cwr_tile = '0;
    logic [3:0]     crd_row = '0, cwr_row = '0;
    logic [RW-1:0]  crd_data, cwr_data = '0;
    logic           cwr_en = 1'b0;

    tile_regfile u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_tile(cmd_tile), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
        .cmd_desc(cmd_desc), .cmd_ready(cmd_ready), .done_o(done_o), .err_o(err_o),
        .cfg_out(cfg_out), .abort_i(abort_i), .mrd_req(mrd_req), .mrd_addr(mrd_addr),
        .mrd_ack(mrd_ack), .mrd_data(mrd_data), .mwr_req(mwr_req), .mwr_addr(mwr_addr),
        .mwr_data(mwr_data), .mwr_ack(mwr_ack), .crd_tile(crd_tile), .crd_row(crd_row),
        .crd_data(crd_data), .cwr_en(cwr_en), .cwr_tile(cwr_tile), .cwr_row(cwr_row),
        .cwr_data(cwr_data)
    );

    int n_cmp = 0, n_bad = 0, rd_hs = 0, cyc = 0;
    logic [AW+RW-1:0] exp_q [$];

    function automatic logic [RW-1:0] pat(input logic [AW-1:0] a);
        logic [RW-1:0] v;
        for (int i = 0; i < 64; i++) v[i*8 +: 8] = a[9:2] + 8'(i * 3);
        return v;
    endfunction

    function automatic logic [RW-1:0] keep(input int w, input logic [RW-1:0] d);
        logic [RW-1:0] v = d;
        for (int i = 0; i < 64; i++) if (i >= w) v[i*8 +: 8] = 8'h00;
        return v;
    endfunction

    function automatic logic [511:0] mkdesc(input logic [7:0] pal, st,
                                            input logic [63:0] rows, wid);
        logic [511:0] d = '0;
        d[7:0] = pal;
        d[15:8] = st;
        for (int t = 0; t < 8; t++) begin
            d[(16 + t)*8 +: 8] = rows[t*8 +: 8];
            d[(48 + t)*8 +: 8] = wid[t*8 +: 8];
        end
        return d;
    endfunction

    // Memory model: one acknowledge per request, one cycle late
    always @(posedge clk) begin
        mrd_ack  <= mrd_req && !mrd_ack;
        mrd_data <= pat(mrd_addr);
        mwr_ack  <= mwr_req && !mwr_ack;
    end

    // Monitor: count reads, compare stores against the scoreboard
    always @(negedge clk) begin
        if (mrd_req && mrd_ack) rd_hs++;
        if (mwr_req && mwr_ack) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected store act=%h exp=none", mwr_addr);
            end else begin
                logic [AW+RW-1:0] e;
                e = exp_q.pop_front();
                if ({mwr_addr, mwr_data} !== e) begin
                    n_bad++;
                    $display("FAIL R8 store act=%h/%h exp=%h/%h",
                             mwr_addr, mwr_data, e[AW+RW-1:RW], e[RW-1:0]);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL R11 watchdog act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [1:0] op, input logic [2:0] t,
                             input logic [AW-1:0] b, s, input logic [511:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_tile = t;
        cmd_base = b; cmd_stride = s; cmd_desc = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input logic [2:0] t,
                         input logic [AW-1:0] b, s, input logic [511:0] d);
        start_cmd(op, t, b, s, d);
        while (!done_o) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] t, input logic [3:0] r, output logic [RW-1:0] v);
        crd_tile = t; crd_row = r;
        #1 v = crd_data;
    endtask

    task automatic cwr(input logic [2:0] t, input logic [3:0] r, input logic [RW-1:0] v);
        @(negedge clk);
        cwr_en = 1'b1; cwr_tile = t; cwr_row = r; cwr_data = v;
        @(negedge clk);
        cwr_en = 1'b0;
    endtask

    initial begin
        logic [RW-1:0] v;
        logic [511:0] good;
        int hs0, exp_start;
        logic found;

        // R1
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", 512'(cmd_ready), 512'(1));
        chk("R1 done/err", 512'({done_o, err_o}), 512'(0));
        chk("R1 cfg_out", cfg_out, '0);
        rd(3'd2, 4'd7, v);
        chk("R1 tile row", v, '0);

        // R2
        good = mkdesc(8'd1, 8'd0, 64'h0000_0000_0010_0304, 64'h0000_0000_0030_1040);
        issue(2'd0, 3'd0, '0, '0, good | (512'hAB << 40));
        chk("R2 done/err", 512'({done_o, err_o}), 512'(2));
        chk("R2 cfg_out", cfg_out, good);

        // R3
        issue(2'd0, 3'd0, '0, '0, mkdesc(8'd2, 8'd0, 64'h04, 64'h40));
        chk("R3 bad palette err", 512'({done_o, err_o}), 512'(3));
        issue(2'd0, 3'd0, '0, '0, mkdesc(8'd1, 8'd0, 64'h11_0000_0000, 64'h40));
        chk("R3 rows 17 err", 512'({done_o, err_o}), 512'(3));
        issue(2'd0, 3'd0, '0, '0, mkdesc(8'd1, 8'd0, 64'h04, 64'h41_0000_0000));
        chk("R3 width 65 err", 512'({done_o, err_o}), 512'(3));
        issue(2'd0, 3'd0, '0, '0, mkdesc(8'd1, 8'd16, 64'h04, 64'h40));
        chk("R3 start 16 err", 512'({done_o, err_o}), 512'(3));
        chk("R3 cfg unchanged", cfg_out, good);

        // R12
        cwr(3'd0, 4'd10, {8{64'hDEAD_BEEF_0BAD_F00D}});
        cwr(3'd5, 4'd2, {16{32'h1234_5678}});
        rd(3'd0, 4'd10, v);
        chk("R12 tile0 row10", v, {8{64'hDEAD_BEEF_0BAD_F00D}});
        rd(3'd5, 4'd2, v);
        chk("R12 tile5 row2", v, {16{32'h1234_5678}});

        // R5 / R6: tile1, 3 rows, width 16
        issue(2'd1, 3'd1, 32'h100, 32'h40, '0);
        chk("R6 load done", 512'({done_o, err_o}), 512'(2));
        for (int r = 0; r < 3; r++) begin
            rd(3'd1, 4'(r), v);
            chk("R5 strided row", v, keep(16, pat(32'h100 + 32'(r) * 32'h40)));
        end
        rd(3'd1, 4'd5, v);
        chk("R6 tail row", v, '0);

        // R5 stride zero, R6 clears compute-written row above count
        issue(2'd1, 3'd0, 32'h200, 32'h0, '0);
        rd(3'd0, 4'd3, v);
        chk("R5 stride zero", v, pat(32'h200));
        rd(3'd0, 4'd10, v);
        chk("R6 row above count", v, '0);

        // R8 store via scoreboard
        for (int r = 0; r < 3; r++)
            exp_q.push_back({32'h800 + 32'(r) * 32'h100,
                             keep(16, pat(32'h100 + 32'(r) * 32'h40))});
        issue(2'd2, 3'd1, 32'h800, 32'h100, '0);
        chk("R8 all rows stored", 512'(exp_q.size()), 512'(0));

        // R7 abort mid-load of tile2 (16 rows, width 48)
        start_cmd(2'd1, 3'd2, 32'h1000, 32'h40, '0);
        hs0 = rd_hs;
        found = 1'b0;
        while (!found) begin
            @(negedge clk);
            #1;
            if ((rd_hs - hs0) >= 3 && !mrd_ack && mrd_req) found = 1'b1;
        end
        abort_i = 1'b1;
        exp_start = rd_hs - hs0;
        @(negedge clk);
        abort_i = 1'b0;
        while (!done_o) @(negedge clk);
        chk("R7 resume row saved", 512'(cfg_out[15:8]), 512'(exp_start));
        rd(3'd2, 4'd0, v);
        chk("R7 rows before abort", v, keep(48, pat(32'h1000)));

        // R7 resume, R11 command and compute write while busy ignored
        hs0 = rd_hs;
        start_cmd(2'd1, 3'd2, 32'h1000, 32'h40, '0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_tile = 3'd1;
        cwr_en = 1'b1; cwr_tile = 3'd1; cwr_row = 4'd1; cwr_data = '1;
        @(negedge clk);
        cmd_valid = 1'b0; cwr_en = 1'b0;
        while (!done_o) @(negedge clk);
        chk("R7 resumed row count", 512'(rd_hs - hs0), 512'(16 - exp_start));
        chk("R7 resume row cleared", 512'(cfg_out[15:8]), 512'(0));
        rd(3'd2, 4'd15, v);
        chk("R7 last row", v, keep(48, pat(32'h1000 + 32'd15 * 32'h40)));
        rd(3'd1, 4'd0, v);
        chk("R11 busy cmd ignored", v, keep(16, pat(32'h100)));
        rd(3'd1, 4'd1, v);
        chk("R11 busy write ignored", v, keep(16, pat(32'h140)));

        // R9
        issue(2'd3, 3'd2, '0, '0, '0);
        chk("R9 zero done", 512'({done_o, err_o}), 512'(2));
        rd(3'd2, 4'd9, v);
        chk("R9 zeroed row", v, '0);
        rd(3'd1, 4'd2, v);
        chk("R9 other tile kept", v, keep(16, pat(32'h180)));

        // R10 row count zero
        hs0 = rd_hs;
        issue(2'd3, 3'd3, '0, '0, '0);
        chk("R10 zero empty tile err", 512'({done_o, err_o}), 512'(3));
        issue(2'd1, 3'd3, 32'h300, 32'h40, '0);
        chk("R10 load empty tile err", 512'({done_o, err_o}), 512'(3));
        issue(2'd2, 3'd3, 32'h300, 32'h40, '0);
        chk("R10 store empty tile err", 512'({done_o, err_o}), 512'(3));
        chk("R10 no memory reads", 512'(rd_hs - hs0), 512'(0));

        // R4
        issue(2'd0, 3'd0, '0, '0, mkdesc(8'd0, 8'd0, 64'h04, 64'h40));
        chk("R4 cfg_out zero", cfg_out, '0);
        rd(3'd1, 4'd0, v);
        chk("R4 tile1 cleared", v, '0);
        rd(3'd5, 4'd2, v);
        chk("R4 tile5 cleared", v, '0);

        // R10 palette 0
        issue(2'd1, 3'd0, 32'h200, 32'h0, '0);
        chk("R10 unconfigured load err", 512'({done_o, err_o}), 512'(3));
        chk("R10 no reads unconfigured", 512'(rd_hs - hs0), 512'(0));

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule